// File: doc/BRIEF.md
# Reset-Window VALID Monitor

A passive checker that sits beside one AXI interface and watches its five VALID lines (write address, write data, write response, read address, read data) against the interface's active-low reset. It sets no value on the interface. It records any VALID that is high while the interface is held in reset. It also records any VALID that is high on the first clock edge at which reset is seen released. A transfer may begin only on a later edge, one at which reset was already high on the edge before.

Each breach sets a sticky flag for that channel and raises a one-cycle pulse that carries the code of the lowest-numbered offending channel. A 16-bit saturating counter totals the cycles that held a breach. The checker has its own active-low clear, which is separate from the watched reset. As a result, a breach found during reset remains visible after the interface leaves reset. Address and data inputs are accepted only so that the monitor can be wired to a full interface. Their values never affect the result.

Top module: `rst_valid_checker`

## Requirements
- R1: The watched reset `mon_rst_n` is active-low and is sampled on every rising clock edge, whenever in the cycle it fell. Any VALID that is high at an edge where `mon_rst_n` is 0 sets that channel's bit in `viol_flags`. The bit index equals the channel code, which is 0 for write address, 1 for write data, 2 for write response, 3 for read address and 4 for read data.
- R2: A VALID that is high at the first edge where `mon_rst_n` is 1 after an edge where it was 0 is a breach and sets that channel's flag.
- R3: A VALID that is high at an edge where `mon_rst_n` is 1 and was also 1 at the previous edge raises no flag, no pulse and no count.
- R4: The values on `aw_addr`, `ar_addr` and `w_data` have no effect on any output, during reset or after it.
- R5: After an edge with at least one breach, `viol_pulse` is 1 for exactly the following cycle and `viol_code` holds the lowest breaching channel code. After an edge with no breach, `viol_pulse` is 0 and `viol_code` is 0.
- R6: Flags in `viol_flags` stay set through later reset cycles and legal traffic until the checker is cleared.
- R7: `err_count` rises by exactly one per edge that holds a breach, however many channels breach at that edge, and it saturates at 65535.
- R8: While `chk_clr_n` is 0, the flags, pulse, code and count are 0. The first edge after the clear is treated as if reset had been low on the edge before it, so a VALID that is high there is a breach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the watched interface |
| chk_clr_n | input | 1 | Active-low clear of the checker's own state |
| mon_rst_n | input | 1 | Watched interface reset, active-low |
| aw_valid | input | 1 | Write address VALID |
| w_valid | input | 1 | Write data VALID |
| b_valid | input | 1 | Write response VALID |
| ar_valid | input | 1 | Read address VALID |
| r_valid | input | 1 | Read data VALID |
| aw_addr | input | ADDR_W | Write address, not checked |
| ar_addr | input | ADDR_W | Read address, not checked |
| w_data | input | DATA_W | Write data, not checked |
| viol_flags | output | 5 | Sticky per-channel breach flags, indexed by channel code |
| viol_pulse | output | 1 | One-cycle breach indication |
| viol_code | output | 3 | Lowest breaching channel code while the pulse is high |
| err_count | output | CNT_W | Saturating count of breaching cycles |

## Verification
The assertions check, on every cycle, the rules that follow from one edge to the next. A breach must set its flag and pulse on the next edge. A flag must hold once set. The pulse must drop after a clean edge. The counter must never move by more than one and must stay fixed at full scale. An edge with reset high after another edge with reset high must never open the breach window. Only the scenarios can show the following: which channel wins when several breach together, the exact count after mixed runs, flags surviving a later reset, address garbage having no effect, the release-edge breach, the post-clear first edge, and saturation after a long fault.

// File: rtl/rstchk_pkg.sv
package rstchk_pkg;
  localparam int CH_N   = 5;
  localparam int CODE_W = $clog2(CH_N);

  typedef logic [CODE_W-1:0] ch_code_t;

  localparam ch_code_t CH_AW = ch_code_t'(0);
  localparam ch_code_t CH_W  = ch_code_t'(1);
  localparam ch_code_t CH_B  = ch_code_t'(2);
  localparam ch_code_t CH_AR = ch_code_t'(3);
  localparam ch_code_t CH_R  = ch_code_t'(4);

  // Lowest set channel index, 0 if none set.
  function automatic ch_code_t lowest_channel(input logic [CH_N-1:0] hits);
    ch_code_t code;
    code = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (hits[i]) code = ch_code_t'(i);
    end
    return code;
  endfunction

  // Saturating increment of a counter of width w (max value passed in).
  function automatic logic [31:0] sat_step(input logic [31:0] value,
                                           input logic [31:0] top);
    return (value >= top) ? top : value + 32'd1;
  endfunction
endpackage

// File: rtl/rstchk_window.sv
module rstchk_window (
  input  logic clk,
  input  logic chk_clr_n,
  input  logic mon_rst_n,
  output logic in_window,
  output logic release_edge
);
  // Previous sampled reset level; cleared to "in reset".
  logic prev_rst_q;

  always_ff @(posedge clk or negedge chk_clr_n) begin
    if (!chk_clr_n) prev_rst_q <= 1'b0;
    else            prev_rst_q <= mon_rst_n;
  end

  assign release_edge = mon_rst_n && !prev_rst_q;
  assign in_window    = !(mon_rst_n && prev_rst_q);

  // R2: an edge with reset low opens the window on the next edge too
  assert_low_opens_next_R2: assert property (@(posedge clk) disable iff (!chk_clr_n)
    !mon_rst_n |=> in_window);

  // R3: two consecutive high samples since clear close the window
  assert_steady_high_closed_R3: assert property (@(posedge clk) disable iff (!chk_clr_n)
    (mon_rst_n && $past(mon_rst_n) && $past(chk_clr_n)) |-> !in_window);
endmodule

// File: rtl/rstchk_lane.sv
module rstchk_lane (
  input  logic clk,
  input  logic chk_clr_n,
  input  logic valid,
  input  logic in_window,
  output logic hit,
  output logic flag
);
  logic flag_q;

  assign hit = valid && in_window;

  always_ff @(posedge clk or negedge chk_clr_n) begin
    if (!chk_clr_n) flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
  end

  assign flag = flag_q;

  // R1: a breach sets the channel flag on the next edge
  assert_hit_sets_flag_R1: assert property (@(posedge clk) disable iff (!chk_clr_n)
    hit |=> flag);

  // R6: a set flag only falls through the checker clear
  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!chk_clr_n)
    flag |=> flag);
endmodule

// File: rtl/rstchk_report.sv
module rstchk_report
  import rstchk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              chk_clr_n,
  input  logic [CH_N-1:0]   hits,
  output logic              pulse,
  output ch_code_t          code,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             any_hit;
  logic             pulse_q;
  ch_code_t         code_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;

  assign any_hit  = |hits;
  assign cnt_next = CNT_W'(sat_step(32'(cnt_q), 32'(CNT_MAX)));

  always_ff @(posedge clk or negedge chk_clr_n) begin
    if (!chk_clr_n) begin
      pulse_q <= 1'b0;
      code_q  <= '0;
      cnt_q   <= '0;
    end else begin
      pulse_q <= any_hit;
      code_q  <= any_hit ? lowest_channel(hits) : '0;
      if (any_hit) cnt_q <= cnt_next;
    end
  end

  assign pulse = pulse_q;
  assign code  = code_q;
  assign count = cnt_q;

  // R5: pulse follows a breaching edge
  assert_pulse_after_hit_R5: assert property (@(posedge clk) disable iff (!chk_clr_n)
    (|hits) |=> pulse);

  // R5: pulse drops after a clean edge
  assert_pulse_drops_R5: assert property (@(posedge clk) disable iff (!chk_clr_n)
    !(|hits) |=> (!pulse && code == '0));

  // R5: reported code names a real channel
  assert_code_range_R5: assert property (@(posedge clk) disable iff (!chk_clr_n)
    pulse |-> (32'(code) < CH_N));

  // R7: counter moves by at most one per edge
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!chk_clr_n)
    ##1 (count == $past(count) || count == $past(count) + 1'b1));

  // R7: counter stays at full scale
  assert_count_sat_R7: assert property (@(posedge clk) disable iff (!chk_clr_n)
    (count == CNT_MAX) |=> (count == CNT_MAX));
endmodule

// File: rtl/rst_valid_checker.sv
module rst_valid_checker
  import rstchk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              chk_clr_n,
  input  logic              mon_rst_n,
  input  logic              aw_valid,
  input  logic              w_valid,
  input  logic              b_valid,
  input  logic              ar_valid,
  input  logic              r_valid,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [DATA_W-1:0] w_data,
  output logic [CH_N-1:0]   viol_flags,
  output logic              viol_pulse,
  output logic [CODE_W-1:0] viol_code,
  output logic [CNT_W-1:0]  err_count
);
  logic [CH_N-1:0] valids;
  logic [CH_N-1:0] hits;
  logic            in_window;
  logic            release_edge;
  logic            unused_fields;

  // Index order is the channel code order.
  assign valids[CH_AW] = aw_valid;
  assign valids[CH_W]  = w_valid;
  assign valids[CH_B]  = b_valid;
  assign valids[CH_AR] = ar_valid;
  assign valids[CH_R]  = r_valid;

  // Payload fields are accepted but deliberately never examined.
  assign unused_fields = ^{aw_addr, ar_addr, w_data};

  rstchk_window u_window (
    .clk          (clk),
    .chk_clr_n    (chk_clr_n),
    .mon_rst_n    (mon_rst_n),
    .in_window    (in_window),
    .release_edge (release_edge)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_lane
    rstchk_lane u_lane (
      .clk       (clk),
      .chk_clr_n (chk_clr_n),
      .valid     (valids[g]),
      .in_window (in_window),
      .hit       (hits[g]),
      .flag      (viol_flags[g])
    );

    // R2: a VALID on the release edge is reported for its channel
    assert_release_edge_flag_R2: assert property (@(posedge clk) disable iff (!chk_clr_n)
      (release_edge && valids[g]) |=> viol_flags[g]);

    // R1: a VALID during reset is reported for its channel
    assert_reset_valid_flag_R1: assert property (@(posedge clk) disable iff (!chk_clr_n)
      (!mon_rst_n && valids[g]) |=> viol_flags[g]);
  end

  rstchk_report #(.CNT_W(CNT_W)) u_report (
    .clk       (clk),
    .chk_clr_n (chk_clr_n),
    .hits      (hits),
    .pulse     (viol_pulse),
    .code      (viol_code),
    .count     (err_count)
  );
endmodule

// File: tb/tb_rst_valid_checker.sv
`timescale 1ns/1ps
module tb_rst_valid_checker;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int CNT_W  = 16;
  localparam int MAXC   = 65535;

  logic              clk = 1'b0;
  logic              chk_clr_n = 1'b0;
  logic              mon_rst_n = 1'b0;
  logic              aw_valid = 1'b0, w_valid = 1'b0, b_valid = 1'b0;
  logic              ar_valid = 1'b0, r_valid = 1'b0;
  logic [ADDR_W-1:0] aw_addr = '0, ar_addr = '0;
  logic [DATA_W-1:0] w_data = '0;
  logic [4:0]        viol_flags;
  logic              viol_pulse;
  logic [2:0]        viol_code;
  logic [CNT_W-1:0]  err_count;

  always #10 clk = ~clk;  // 50 MHz

  rst_valid_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .chk_clr_n(chk_clr_n), .mon_rst_n(mon_rst_n),
    .aw_valid(aw_valid), .w_valid(w_valid), .b_valid(b_valid),
    .ar_valid(ar_valid), .r_valid(r_valid),
    .aw_addr(aw_addr), .ar_addr(ar_addr), .w_data(w_data),
    .viol_flags(viol_flags), .viol_pulse(viol_pulse),
    .viol_code(viol_code), .err_count(err_count)
  );

  typedef struct {
    logic [4:0] flags;
    logic       pulse;
    logic [2:0] code;
    int         count;
    string      tag;
    bit         check;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  // Reference model state, built from the requirements.
  logic       m_prev  = 1'b0;
  logic [4:0] m_flags = '0;
  int         m_count = 0;

  function automatic void model_clear();
    m_prev  = 1'b0;
    m_flags = '0;
    m_count = 0;
  endfunction

  function automatic exp_t model_edge(input logic r, input logic [4:0] v,
                                      input string tag, input bit chk);
    exp_t e;
    logic       open;
    logic [4:0] h;
    open = !(r && m_prev);
    h    = open ? v : 5'b0;
    e.pulse = (h != 0);
    e.code  = 3'd0;
    if (h != 0) begin
      for (int i = 4; i >= 0; i--) if (h[i]) e.code = 3'(i);
      if (m_count < MAXC) m_count++;
    end
    m_flags = m_flags | h;
    m_prev  = r;
    e.flags = m_flags;
    e.count = m_count;
    e.tag   = tag;
    e.check = chk;
    return e;
  endfunction

  // Driver: v bits are {r, ar, b, w, aw} in code order 4..0.
  task automatic step(input logic r, input logic [4:0] v, input string tag,
                      input bit chk = 1'b1);
    @(negedge clk);
    mon_rst_n = r;
    {r_valid, ar_valid, b_valid, w_valid, aw_valid} = v;
    aw_addr = $urandom;
    ar_addr = $urandom;
    w_data  = {$urandom, $urandom};
    exp_q.push_back(model_edge(r, v, tag, chk));
  endtask

  task automatic clear_checker(input string tag);
    exp_t e;
    @(negedge clk);
    chk_clr_n = 1'b0;
    {r_valid, ar_valid, b_valid, w_valid, aw_valid} = 5'b0;
    model_clear();
    e.flags = '0; e.pulse = 1'b0; e.code = '0; e.count = 0;
    e.tag = tag; e.check = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    chk_clr_n = 1'b1;
    exp_q.push_back(model_edge(mon_rst_n, 5'b0, tag, 1'b1));
  endtask

  // Monitor: compares after each rising edge, away from it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.check) begin
          n_checks++;
          if (viol_flags !== e.flags || viol_pulse !== e.pulse ||
              viol_code !== e.code || int'(err_count) != e.count) begin
            n_fail++;
            $display("FAIL %s: flags=%b pulse=%b code=%0d count=%0d expected flags=%b pulse=%b code=%0d count=%0d",
                     e.tag, viol_flags, viol_pulse, viol_code, err_count,
                     e.flags, e.pulse, e.code, e.count);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset state under the checker clear
    clear_checker("R8 clear state");

    // R4: garbage payload while reset held, no VALID
    for (int i = 0; i < 4; i++) step(1'b0, 5'b00000, "R4 payload ignored in reset");
    // R3: release with VALID low, then legal traffic
    step(1'b1, 5'b00000, "R3 release quiet");
    step(1'b1, 5'b00001, "R3 legal aw after release");
    step(1'b1, 5'b11111, "R3 legal all channels");
    step(1'b1, 5'b00000, "R4 payload ignored after reset");

    // R1: write data VALID in reset
    step(1'b0, 5'b00010, "R1 w in reset");
    step(1'b0, 5'b00000, "R5 pulse one cycle");
    // R5, R7: write response and read data together -> code 2, count +1
    step(1'b0, 5'b10100, "R5 lowest code of b and r");
    step(1'b0, 5'b00000, "R7 count once per edge");
    // R2: read address VALID on the release edge
    step(1'b1, 5'b01000, "R2 ar on release edge");
    step(1'b1, 5'b01000, "R3 ar one edge later legal");
    // R6: flags persist over a new reset and traffic
    step(1'b0, 5'b00000, "R6 flags persist in reset");
    step(1'b1, 5'b00000, "R6 flags persist at release");
    step(1'b1, 5'b10000, "R6 flags persist with traffic");

    // R8: first edge after clear counts as release
    mon_rst_n = 1'b1;
    clear_checker("R8 clear wipes flags");
    // clear_checker consumed one edge with reset high, so reopen via a new clear path:
    @(negedge clk);
    chk_clr_n = 1'b0;
    {r_valid, ar_valid, b_valid, w_valid, aw_valid} = 5'b0;
    model_clear();
    begin
      exp_t e;
      e.flags = '0; e.pulse = 1'b0; e.code = '0; e.count = 0;
      e.tag = "R8 clear held"; e.check = 1'b1;
      exp_q.push_back(e);
    end
    @(negedge clk);
    chk_clr_n = 1'b1;
    mon_rst_n = 1'b1;
    r_valid   = 1'b1;
    exp_q.push_back(model_edge(1'b1, 5'b10000, "R8 valid on first edge after clear", 1'b1));
    step(1'b1, 5'b10000, "R8 then legal");

    // R1: reset dropping mid-cycle is seen at the next edge
    @(negedge clk);
    #3 mon_rst_n = 1'b0;
    b_valid = 1'b1;
    r_valid = 1'b0;
    exp_q.push_back(model_edge(1'b0, 5'b00100, "R1 async fall mid-cycle", 1'b1));

    // R7: saturation under a long fault
    for (int i = 0; i < MAXC + 4; i++)
      step(1'b0, 5'b00001, "R7 saturation", (i >= MAXC - 2));
    step(1'b0, 5'b00000, "R7 saturated hold");

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule